// File: doc/BRIEF.md
# Strap Latch and Clock Output Gating

This block sits beside the frequency synthesizer of a board clock generator. Several pins do double duty. While power-on reset is held, they are inputs that carry configuration straps. On the first clock edge after reset releases, the block records those straps once. From then on it lets the same pins drive clocks. The straps give a 3-bit hardware frequency code, a mode bit, a bit that picks the source of the memory clocks, and a CPU supply-level bit. A software select bit decides whether the synthesizer takes the frequency code from the straps or a 4-bit code from a control register.

For every clock output the block produces a run control and an output-driver enable. The run control decides whether the raw clock passes or is held low. The driver enable decides whether the pin drives or floats. The inputs to these controls are the per-output enable bits, a global tri-state bit, and two active-low stop requests. The stop requests exist only when the mode strap was latched low. In that case the two highest memory clock pins become inputs: the highest one stops all CPU clocks and the next one stops all stoppable PCI clocks. A stop is applied or released only on a clock edge at which the raw clock of that group is low, so a gated clock never produces a shortened pulse.

Top module: `clkgen_strap_gate`

## Requirements
- R1: While `rst` is high, `latch_done_o` is 0 and every run and driver-enable output is 0. The latched values read back their defaults: mode 1, memory source 1, strap code 0 and supply level 0.
- R2: The strap pins are captured on the first rising edge of `clk` with `rst` low, and `latch_done_o` is 1 from then on. Later changes on the strap pins do not alter `mode_o`, `mem_src_o`, `vlvl_o` or the hardware code until `rst` is asserted again.
- R3: With `sw_sel_i`=0, `freq_code_o` is {0, latched strap code}. With `sw_sel_i`=1, `freq_code_o` equals `sw_code_i`.
- R4: No output driver is enabled before the latch completes. After it completes, `cpu_oe_o`, `pci_oe_o`, `agp_oe_o`, `ref_oe_o` and both bits of `fix_oe_o` are 1 while tri-state is off. Bit 0 of `fix_oe_o` is the 48 MHz pin and bit 1 is the 24 MHz pin.
- R5: While `tri_all_i` is 1, every driver-enable output and every run output is 0.
- R6: An output whose enable bit is 0 has its run output at 0.
- R7: With mode latched as 1, the two highest memory outputs are driven like the other memory outputs, and `pad_dual_a_i` and `pad_dual_b_i` have no effect on any run output.
- R8: With mode latched as 0, the two highest memory outputs have run and driver enable at 0. `pad_dual_a_i`=0 stops every CPU run output, and `pad_dual_b_i`=0 stops every stoppable PCI run output.
- R9: A stop request is applied, and a release is taken, only on a `clk` edge at which the raw phase input of that group is 0. Edges with the phase at 1 leave the group's run outputs unchanged.
- R10: The free-running PCI output, the memory, graphics-port and reference outputs do not respond to either stop request.
- R11: `mem_src_o` holds the latched memory-source strap. A value of 1 means the memory clocks follow the CPU frequency, and 0 means they follow the graphics-port frequency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, synchronous to the raw phases |
| rst | input | 1 | Power-on reset, active high, synchronous |
| pad_fs_i | input | 3 | Frequency-select strap pins |
| pad_mode_i | input | 1 | Mode strap pin |
| pad_memsrc_i | input | 1 | Memory-clock source strap pin |
| pad_vlvl_i | input | 1 | CPU supply-level strap pin |
| pad_dual_a_i | input | 1 | Highest memory pin read as input; CPU stop, active low, when mode=0 |
| pad_dual_b_i | input | 1 | Next memory pin read as input; PCI stop, active low, when mode=0 |
| sw_sel_i | input | 1 | 1 = software frequency code, 0 = strap code |
| sw_code_i | input | 4 | Software frequency code |
| tri_all_i | input | 1 | Global tri-state request |
| en_cpu_i | input | N_CPU | Per-output CPU clock enables |
| en_pci_i | input | N_PCI | Per-output stoppable PCI clock enables |
| en_pcif_i | input | 1 | Free-running PCI clock enable |
| en_mem_i | input | N_MEM | Per-output memory clock enables |
| en_agp_i | input | N_AGP | Graphics-port clock enables |
| en_ref_i | input | N_REF | Reference clock enables |
| cpu_ph_i | input | 1 | Raw CPU clock phase level |
| pci_ph_i | input | 1 | Raw PCI clock phase level |
| latch_done_o | output | 1 | Straps captured |
| mode_o | output | 1 | Latched mode |
| mem_src_o | output | 1 | Latched memory-clock source |
| vlvl_o | output | 1 | Latched CPU supply level |
| freq_code_o | output | 4 | Selected frequency code |
| cpu_run_o | output | N_CPU | CPU clock run controls |
| cpu_oe_o | output | 1 | CPU clock driver enable |
| pci_run_o | output | N_PCI | Stoppable PCI clock run controls |
| pci_oe_o | output | 1 | PCI clock driver enable (includes free-running) |
| pcif_run_o | output | 1 | Free-running PCI clock run control |
| mem_run_o | output | N_MEM | Memory clock run controls |
| mem_oe_o | output | N_MEM | Memory clock driver enables |
| agp_run_o | output | N_AGP | Graphics-port clock run controls |
| agp_oe_o | output | 1 | Graphics-port clock driver enable |
| ref_run_o | output | N_REF | Reference clock run controls |
| ref_oe_o | output | 1 | Reference clock driver enable |
| fix_oe_o | output | 2 | Fixed 48/24 MHz driver enables |

## Verification
The bench builds the block with three CPU outputs, four stoppable PCI outputs and six memory outputs. With six memory outputs, the dual-use pins are memory indices 5 and 4, so the mask check confirms that the stop pins follow `N_MEM`. With three CPU outputs, a partly enabled CPU pattern is easy to tell apart from all-on and all-off. The bench releases reset twice with opposite mode straps, so both the stop-input role and the clock-output role of the dual pins are exercised. It also steps the raw phases high and low around each stop request and each release.

// File: rtl/clkgen_strap_pkg.sv
package clkgen_strap_pkg;

    localparam int FS_W   = 3;
    localparam int CODE_W = 4;

    typedef struct packed {
        logic [FS_W-1:0] fs;
        logic            mode;
        logic            mem_src;
        logic            vlvl;
    } strap_t;

    localparam strap_t STRAP_DEFAULT = '{fs: '0, mode: 1'b1, mem_src: 1'b1, vlvl: 1'b0};

    typedef enum logic [1:0] {
        GRP_PLAIN = 2'd0,
        GRP_CPU   = 2'd1,
        GRP_PCI   = 2'd2
    } stop_grp_e;

    function automatic logic [CODE_W-1:0] pick_code(
        input logic              sw_sel,
        input logic [CODE_W-1:0] sw_code,
        input logic [FS_W-1:0]   hw_code
    );
        logic [CODE_W-1:0] r;
        if (sw_sel) r = sw_code;
        else        r = CODE_W'(hw_code);
        return r;
    endfunction

endpackage

// File: rtl/clkgen_strap_latch.sv
module clkgen_strap_latch
    import clkgen_strap_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  strap_t pads_i,
    output strap_t strap_o,
    output logic   done_o
);

    // One-shot capture on the first edge out of reset; frozen afterwards.
    always_ff @(posedge clk) begin
        if (rst) begin
            strap_o <= STRAP_DEFAULT;
            done_o  <= 1'b0;
        end else if (!done_o) begin
            strap_o <= pads_i;
            done_o  <= 1'b1;
        end
    end

endmodule

// File: rtl/clkgen_stop_sync.sv
module clkgen_stop_sync (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    input  logic ph_i,
    output logic stopped_o
);

    // State may only change on an edge where the raw clock is low.
    always_ff @(posedge clk) begin
        if (rst)        stopped_o <= 1'b0;
        else if (!ph_i) stopped_o <= req_i;
    end

endmodule

// File: rtl/clkgen_gate_bank.sv
module clkgen_gate_bank #(
    parameter int N = 4
) (
    input  logic [N-1:0] en_i,
    input  logic         allow_i,
    input  logic         stop_i,
    output logic [N-1:0] run_o
);

    logic pass;

    assign pass = allow_i & ~stop_i;

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign run_o[i] = en_i[i] & pass;
    end

endmodule

// File: rtl/clkgen_strap_gate.sv
module clkgen_strap_gate
    import clkgen_strap_pkg::*;
#(
    parameter int N_CPU = 4,
    parameter int N_PCI = 5,
    parameter int N_MEM = 12,
    parameter int N_AGP = 2,
    parameter int N_REF = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FS_W-1:0]   pad_fs_i,
    input  logic              pad_mode_i,
    input  logic              pad_memsrc_i,
    input  logic              pad_vlvl_i,
    input  logic              pad_dual_a_i,
    input  logic              pad_dual_b_i,
    input  logic              sw_sel_i,
    input  logic [CODE_W-1:0] sw_code_i,
    input  logic              tri_all_i,
    input  logic [N_CPU-1:0]  en_cpu_i,
    input  logic [N_PCI-1:0]  en_pci_i,
    input  logic              en_pcif_i,
    input  logic [N_MEM-1:0]  en_mem_i,
    input  logic [N_AGP-1:0]  en_agp_i,
    input  logic [N_REF-1:0]  en_ref_i,
    input  logic              cpu_ph_i,
    input  logic              pci_ph_i,
    output logic              latch_done_o,
    output logic              mode_o,
    output logic              mem_src_o,
    output logic              vlvl_o,
    output logic [CODE_W-1:0] freq_code_o,
    output logic [N_CPU-1:0]  cpu_run_o,
    output logic              cpu_oe_o,
    output logic [N_PCI-1:0]  pci_run_o,
    output logic              pci_oe_o,
    output logic              pcif_run_o,
    output logic [N_MEM-1:0]  mem_run_o,
    output logic [N_MEM-1:0]  mem_oe_o,
    output logic [N_AGP-1:0]  agp_run_o,
    output logic              agp_oe_o,
    output logic [N_REF-1:0]  ref_run_o,
    output logic              ref_oe_o,
    output logic [1:0]        fix_oe_o
);

    // The two highest memory indices share pins with the stop inputs.
    localparam int IDX_CPU_STOP = N_MEM - 1;
    localparam int IDX_PCI_STOP = N_MEM - 2;

    strap_t pads;
    strap_t strap;
    logic   done;
    logic   drive_ok;
    logic   cpu_req;
    logic   pci_req;
    logic   cpu_stopped;
    logic   pci_stopped;
    logic [1:0] fix_oe;

    assign pads = '{fs: pad_fs_i, mode: pad_mode_i, mem_src: pad_memsrc_i, vlvl: pad_vlvl_i};

    clkgen_strap_latch u_latch (
        .clk    (clk),
        .rst    (rst),
        .pads_i (pads),
        .strap_o(strap),
        .done_o (done)
    );

    assign drive_ok = done & ~tri_all_i;

    // Stop requests exist only when the dual pins were latched as inputs.
    assign cpu_req = done & ~strap.mode & ~pad_dual_a_i;
    assign pci_req = done & ~strap.mode & ~pad_dual_b_i;

    clkgen_stop_sync u_cpu_stop (
        .clk      (clk),
        .rst      (rst),
        .req_i    (cpu_req),
        .ph_i     (cpu_ph_i),
        .stopped_o(cpu_stopped)
    );

    clkgen_stop_sync u_pci_stop (
        .clk      (clk),
        .rst      (rst),
        .req_i    (pci_req),
        .ph_i     (pci_ph_i),
        .stopped_o(pci_stopped)
    );

    clkgen_gate_bank #(.N(N_CPU)) u_cpu_gate (
        .en_i   (en_cpu_i),
        .allow_i(drive_ok),
        .stop_i (cpu_stopped),
        .run_o  (cpu_run_o)
    );

    clkgen_gate_bank #(.N(N_PCI)) u_pci_gate (
        .en_i   (en_pci_i),
        .allow_i(drive_ok),
        .stop_i (pci_stopped),
        .run_o  (pci_run_o)
    );

    clkgen_gate_bank #(.N(1)) u_pcif_gate (
        .en_i   (en_pcif_i),
        .allow_i(drive_ok),
        .stop_i (1'b0),
        .run_o  (pcif_run_o)
    );

    clkgen_gate_bank #(.N(N_AGP)) u_agp_gate (
        .en_i   (en_agp_i),
        .allow_i(drive_ok),
        .stop_i (1'b0),
        .run_o  (agp_run_o)
    );

    clkgen_gate_bank #(.N(N_REF)) u_ref_gate (
        .en_i   (en_ref_i),
        .allow_i(drive_ok),
        .stop_i (1'b0),
        .run_o  (ref_run_o)
    );

    // Memory outputs: dual-use indices drive only when mode latched high.
    for (genvar i = 0; i < N_MEM; i++) begin : g_mem
        if (i == IDX_CPU_STOP || i == IDX_PCI_STOP) begin : g_dual
            assign mem_oe_o[i] = drive_ok & strap.mode;
        end else begin : g_plain
            assign mem_oe_o[i] = drive_ok;
        end
        assign mem_run_o[i] = en_mem_i[i] & mem_oe_o[i];
    end

    assign fix_oe = {2{drive_ok}};

    assign cpu_oe_o     = drive_ok;
    assign pci_oe_o     = drive_ok;
    assign agp_oe_o     = drive_ok;
    assign ref_oe_o     = drive_ok;
    assign fix_oe_o     = fix_oe;
    assign latch_done_o = done;
    assign mode_o       = strap.mode;
    assign mem_src_o    = strap.mem_src;
    assign vlvl_o       = strap.vlvl;
    assign freq_code_o  = pick_code(sw_sel_i, sw_code_i, strap.fs);

endmodule

// File: rtl/clkgen_strap_chk.sv
module clkgen_strap_chk
    import clkgen_strap_pkg::*;
#(
    parameter int N_CPU = 4,
    parameter int N_PCI = 5,
    parameter int N_MEM = 12,
    parameter int N_AGP = 2,
    parameter int N_REF = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              sw_sel_i,
    input logic [CODE_W-1:0] sw_code_i,
    input logic              tri_all_i,
    input logic [N_CPU-1:0]  en_cpu_i,
    input logic [N_PCI-1:0]  en_pci_i,
    input logic              en_pcif_i,
    input logic              cpu_ph_i,
    input logic              pci_ph_i,
    input logic              latch_done_o,
    input logic              mode_o,
    input logic              mem_src_o,
    input logic              vlvl_o,
    input logic [CODE_W-1:0] freq_code_o,
    input logic [N_CPU-1:0]  cpu_run_o,
    input logic              cpu_oe_o,
    input logic [N_PCI-1:0]  pci_run_o,
    input logic              pci_oe_o,
    input logic              pcif_run_o,
    input logic [N_MEM-1:0]  mem_oe_o,
    input logic              agp_oe_o,
    input logic              ref_oe_o,
    input logic [1:0]        fix_oe_o
);

    assert_done_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        latch_done_o |=> latch_done_o)
        else $error("R2 latch completion dropped");

    assert_no_resample_R2: assert property (@(posedge clk) disable iff (rst)
        (latch_done_o && $past(latch_done_o)) |-> $stable({mode_o, mem_src_o, vlvl_o}))
        else $error("R2 strap resampled");

    assert_hw_code_R3: assert property (@(posedge clk) disable iff (rst)
        !sw_sel_i |-> (freq_code_o[CODE_W-1] == 1'b0))
        else $error("R3 hardware code too wide");

    assert_sw_code_R3: assert property (@(posedge clk) disable iff (rst)
        sw_sel_i |-> (freq_code_o == sw_code_i))
        else $error("R3 software code not selected");

    assert_quiet_before_latch_R4: assert property (@(posedge clk) disable iff (rst)
        !latch_done_o |-> (!cpu_oe_o && !pci_oe_o && mem_oe_o == '0 && fix_oe_o == '0))
        else $error("R4 driver on before latch");

    assert_tristate_R5: assert property (@(posedge clk) disable iff (rst)
        tri_all_i |-> (!cpu_oe_o && !pci_oe_o && !agp_oe_o && !ref_oe_o
                       && mem_oe_o == '0 && fix_oe_o == '0 && cpu_run_o == '0))
        else $error("R5 output driven in tri-state");

    assert_mode1_no_stop_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_o && latch_done_o && !tri_all_i) |-> (cpu_run_o == en_cpu_i && pci_run_o == en_pci_i))
        else $error("R7 stop acted in clock-output mode");

    assert_cpu_align_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(cpu_ph_i) && $past(latch_done_o) && $stable(en_cpu_i) && $stable(tri_all_i))
            |-> $stable(cpu_run_o))
        else $error("R9 CPU gate moved while phase high");

    assert_pci_align_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(pci_ph_i) && $past(latch_done_o) && $stable(en_pci_i) && $stable(tri_all_i))
            |-> $stable(pci_run_o))
        else $error("R9 PCI gate moved while phase high");

    assert_pcif_free_R10: assert property (@(posedge clk) disable iff (rst)
        (latch_done_o && !tri_all_i && en_pcif_i) |-> pcif_run_o)
        else $error("R10 free-running PCI clock stopped");

endmodule

bind clkgen_strap_gate clkgen_strap_chk #(
    .N_CPU(N_CPU), .N_PCI(N_PCI), .N_MEM(N_MEM), .N_AGP(N_AGP), .N_REF(N_REF)
) u_chk (.*);

// File: tb/sim_clkgen_strap_gate.sv
module sim_clkgen_strap_gate;

    localparam int NC = 3;
    localparam int NP = 4;
    localparam int NM = 6;
    localparam int NA = 2;
    localparam int NR = 2;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst = 1'b1;
    logic [2:0]    pad_fs = 3'b101;
    logic          pad_mode = 1'b0, pad_memsrc = 1'b0, pad_vlvl = 1'b1;
    logic          pad_a = 1'b1, pad_b = 1'b1;
    logic          sw_sel = 1'b0;
    logic [3:0]    sw_code = 4'h0;
    logic          tri_all = 1'b0;
    logic [NC-1:0] en_cpu = '1;
    logic [NP-1:0] en_pci = '1;
    logic          en_pcif = 1'b1;
    logic [NM-1:0] en_mem = '1;
    logic [NA-1:0] en_agp = '1;
    logic [NR-1:0] en_ref = '1;
    logic          cpu_ph = 1'b1, pci_ph = 1'b1;

    logic          done_o, mode_o, msrc_o, vlvl_o, cpu_oe, pci_oe, pcif_run, agp_oe, ref_oe;
    logic [3:0]    code_o;
    logic [NC-1:0] cpu_run;
    logic [NP-1:0] pci_run;
    logic [NM-1:0] mem_run, mem_oe;
    logic [NA-1:0] agp_run;
    logic [NR-1:0] ref_run;
    logic [1:0]    fix_oe;

    clkgen_strap_gate #(.N_CPU(NC), .N_PCI(NP), .N_MEM(NM), .N_AGP(NA), .N_REF(NR)) u0 (
        .clk(clk), .rst(rst), .pad_fs_i(pad_fs), .pad_mode_i(pad_mode),
        .pad_memsrc_i(pad_memsrc), .pad_vlvl_i(pad_vlvl), .pad_dual_a_i(pad_a),
        .pad_dual_b_i(pad_b), .sw_sel_i(sw_sel), .sw_code_i(sw_code), .tri_all_i(tri_all),
        .en_cpu_i(en_cpu), .en_pci_i(en_pci), .en_pcif_i(en_pcif), .en_mem_i(en_mem),
        .en_agp_i(en_agp), .en_ref_i(en_ref), .cpu_ph_i(cpu_ph), .pci_ph_i(pci_ph),
        .latch_done_o(done_o), .mode_o(mode_o), .mem_src_o(msrc_o), .vlvl_o(vlvl_o),
        .freq_code_o(code_o), .cpu_run_o(cpu_run), .cpu_oe_o(cpu_oe), .pci_run_o(pci_run),
        .pci_oe_o(pci_oe), .pcif_run_o(pcif_run), .mem_run_o(mem_run), .mem_oe_o(mem_oe),
        .agp_run_o(agp_run), .agp_oe_o(agp_oe), .ref_run_o(ref_run), .ref_oe_o(ref_oe),
        .fix_oe_o(fix_oe)
    );

    typedef enum int {
        F_DONE, F_MODE, F_MSRC, F_VLVL, F_CODE, F_CPURUN, F_CPUOE, F_PCIRUN,
        F_PCIOE, F_PCIF, F_MEMRUN, F_MEMOE, F_AGP, F_REF, F_FIX
    } fld_e;

    typedef struct {
        string       tag;
        fld_e        fld;
        logic [31:0] exp;
    } item_t;

    item_t q[$];
    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    function automatic logic [31:0] observe(fld_e f);
        case (f)
            F_DONE:   return 32'(done_o);
            F_MODE:   return 32'(mode_o);
            F_MSRC:   return 32'(msrc_o);
            F_VLVL:   return 32'(vlvl_o);
            F_CODE:   return 32'(code_o);
            F_CPURUN: return 32'(cpu_run);
            F_CPUOE:  return 32'(cpu_oe);
            F_PCIRUN: return 32'(pci_run);
            F_PCIOE:  return 32'(pci_oe);
            F_PCIF:   return 32'(pcif_run);
            F_MEMRUN: return 32'(mem_run);
            F_MEMOE:  return 32'(mem_oe);
            F_AGP:    return 32'(agp_run);
            F_REF:    return 32'(ref_run);
            default:  return 32'(fix_oe);
        endcase
    endfunction

    // Driver side: push the expectation for the sample after the next edge.
    task automatic expect_val(input string tag, input fld_e f, input logic [31:0] v);
        item_t it;
        it.tag = tag;
        it.fld = f;
        it.exp = v;
        q.push_back(it);
    endtask

    // Monitor: compare everything queued, 1 ns after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                act = observe(it.fld);
                n_run++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s %s: actual %0h expected %0h", it.tag, it.fld.name(), act, it.exp);
                end
            end
        end
    end

    initial begin
        #800000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        expect_val("R1 reset", F_DONE, 0);
        expect_val("R1 reset", F_MODE, 1);
        expect_val("R1 reset", F_MSRC, 1);
        expect_val("R1 reset", F_CODE, 0);
        expect_val("R1 reset", F_CPUOE, 0);
        expect_val("R1 reset", F_MEMOE, 0);
        expect_val("R1 reset", F_CPURUN, 0);
        expect_val("R4 pre-latch", F_FIX, 0);

        // R2 / R3 / R11: release reset, straps fs=101 mode=0 memsrc=0 vlvl=1
        @(negedge clk);
        rst = 1'b0;
        expect_val("R2 latch", F_DONE, 1);
        expect_val("R2 latch", F_MODE, 0);
        expect_val("R11 memsrc", F_MSRC, 0);
        expect_val("R2 latch", F_VLVL, 1);
        expect_val("R3 hw code", F_CODE, 32'h5);

        // R2: pins change later, nothing resampled
        @(negedge clk);
        pad_fs = 3'b010; pad_mode = 1'b1; pad_memsrc = 1'b1; pad_vlvl = 1'b0;
        expect_val("R2 no resample", F_MODE, 0);
        expect_val("R2 no resample", F_CODE, 32'h5);
        expect_val("R2 no resample", F_VLVL, 1);

        // R3: software code
        @(negedge clk);
        sw_sel = 1'b1; sw_code = 4'hC;
        expect_val("R3 sw code", F_CODE, 32'hC);
        @(negedge clk);
        sw_sel = 1'b0;
        expect_val("R3 back to hw", F_CODE, 32'h5);

        // R4 / R8: drivers after latch, dual memory pins are inputs
        expect_val("R4 drivers", F_CPUOE, 1);
        expect_val("R4 drivers", F_PCIOE, 1);
        expect_val("R4 drivers", F_FIX, 32'h3);
        expect_val("R8 dual pins off", F_MEMOE, 32'h0F);
        expect_val("R8 dual pins off", F_MEMRUN, 32'h0F);

        // R6: per-output enables
        @(negedge clk);
        en_cpu = 3'b101; en_mem = 6'b000110;
        expect_val("R6 enables", F_CPURUN, 32'h5);
        expect_val("R6 enables", F_MEMRUN, 32'h06);
        @(negedge clk);
        en_cpu = '1; en_mem = '1;
        expect_val("R6 restore", F_CPURUN, 32'h7);

        // R9: CPU stop asked while phase high -> no change
        @(negedge clk);
        pad_a = 1'b0; cpu_ph = 1'b1;
        expect_val("R9 hold high", F_CPURUN, 32'h7);
        // R8: phase low -> CPU clocks stop
        @(negedge clk);
        cpu_ph = 1'b0;
        expect_val("R8 cpu stop", F_CPURUN, 32'h0);
        expect_val("R10 pci not stopped", F_PCIRUN, 32'hF);
        expect_val("R10 mem not stopped", F_MEMRUN, 32'h0F);
        // R9: release while phase high stays stopped
        @(negedge clk);
        pad_a = 1'b1; cpu_ph = 1'b1;
        expect_val("R9 release high", F_CPURUN, 32'h0);
        @(negedge clk);
        cpu_ph = 1'b0;
        expect_val("R9 release low", F_CPURUN, 32'h7);

        // R8 / R10: PCI stop
        @(negedge clk);
        pad_b = 1'b0; pci_ph = 1'b0;
        expect_val("R8 pci stop", F_PCIRUN, 32'h0);
        expect_val("R10 pcif free", F_PCIF, 1);
        expect_val("R10 agp free", F_AGP, 32'h3);
        expect_val("R10 ref free", F_REF, 32'h3);
        expect_val("R10 cpu untouched", F_CPURUN, 32'h7);
        @(negedge clk);
        pad_b = 1'b1;
        expect_val("R9 pci release", F_PCIRUN, 32'hF);

        // R5: global tri-state
        @(negedge clk);
        tri_all = 1'b1;
        expect_val("R5 tristate", F_CPUOE, 0);
        expect_val("R5 tristate", F_MEMOE, 0);
        expect_val("R5 tristate", F_FIX, 0);
        expect_val("R5 tristate", F_CPURUN, 0);
        expect_val("R5 tristate", F_PCIF, 0);
        @(negedge clk);
        tri_all = 1'b0;
        expect_val("R5 tristate off", F_CPUOE, 1);

        // Second power-up with mode=1 memsrc=1 fs=011
        @(negedge clk);
        rst = 1'b1; pad_fs = 3'b011; pad_mode = 1'b1; pad_memsrc = 1'b1;
        expect_val("R1 re-reset", F_DONE, 0);
        expect_val("R1 re-reset", F_CPUOE, 0);
        @(negedge clk);
        rst = 1'b0;
        expect_val("R7 mode1", F_MODE, 1);
        expect_val("R11 memsrc cpu", F_MSRC, 1);
        expect_val("R3 hw code 2", F_CODE, 32'h3);
        expect_val("R7 dual pins drive", F_MEMOE, 32'h3F);
        expect_val("R7 dual pins run", F_MEMRUN, 32'h3F);

        // R7: stop pins ignored in clock-output mode
        @(negedge clk);
        pad_a = 1'b0; pad_b = 1'b0; cpu_ph = 1'b0; pci_ph = 1'b0;
        expect_val("R7 no cpu stop", F_CPURUN, 32'h7);
        expect_val("R7 no pci stop", F_PCIRUN, 32'hF);
        @(negedge clk);
        expect_val("R7 still running", F_CPURUN, 32'h7);

        @(posedge clk);
        #2;
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule